// File: doc/BRIEF.md
# Dual-Mode Pulse Width Timer

This block is an 8-bit down-counter with two uses. A single shared data register serves as the reload value in interval mode and as the capture register in pulse-width mode. Software reaches it through a small register port with two addresses: a control/status byte and the shared data register. The counter steps only on cycles where the count-clock enable is high, so any prescaler sits outside the block.

In interval mode the counter loads the data register when software sets the run bit. Every step from 1 to 0 is an underflow. Each underflow inverts an internal timer output bit and sets a sticky flag. Then either the count restarts from the data register (reload) or the run bit drops and counting stops (one-shot).

In pulse-width mode, setting the run bit arms a measurement. The measured input is synchronized through two flops. The selected starting edge loads FFh. The opposite edge copies the live count into the data register and sets a completion flag and a buffer-full flag. If the run bit is cleared while a measurement is open, nothing is captured.

An interrupt line combines an enable bit with the three flags. An output pin carries either the timer output bit or a general-purpose port value.

Top module: `pwc_timer`

## Requirements
- R1: After reset the control byte (address 0) reads 00h, the data register (address 1) reads 00h, `irq_o` is 0, and `pin_o` follows `gpio_i`.
- R2: Interval mode (`mode_i`=0). Writing control bit 7 (run) from 0 to 1 loads the counter from the data register, which is written at address 1. The counter decrements only on cycles with `cnt_en_i`=1. After B enabled cycles it steps from 01h to 00h. That step sets control bit 2 (underflow flag) and inverts the timer output bit.
- R3: In reload operation (`one_shot_i`=0) the counter restarts from the data register at each underflow, so the timer output toggles every B enabled cycles.
- R4: In one-shot operation (`one_shot_i`=1) the first underflow clears the run bit and stops the counter, and the timer output does not toggle again.
- R5: Pulse-width mode (`mode_i`=1). While run=1, the starting edge loads FFh. The starting edge is rising when `edge_sel_i`=0 and falling when it is 1. The opposite edge copies the live count into the data register and sets control bit 1 (done) and bit 0 (full). A pulse lasting P enabled cycles therefore captures (256 − P) mod 256.
- R6: In pulse-width mode a step from 01h to 00h sets the underflow flag, and counting wraps and continues. A pulse of 256 or more cycles therefore sets bit 2 along with the capture.
- R7: Clearing the run bit while a measurement is open leaves the data register and the done flag unchanged. Setting run again re-arms with a count of FFh.
- R8: Writing 0 to bit 2 or bit 1 clears that flag, and writing 1 leaves it unchanged. A set event in the same cycle as a clearing write wins.
- R9: Bit 0 (full) ignores writes and clears when address 1 is read.
- R10: `irq_o` = bit 5 (interrupt enable) AND (underflow OR done OR full).
- R11: Bit 6 (pin select) drives `pin_sel_o`. When bit 6 is 1, `pin_o` carries the timer output bit; when it is 0, `pin_o` carries `gpio_i`.
- R12: Control bits 4 and 3 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (address 1 read clears full) |
| addr_i | input | 1 | 0: control/status, 1: data register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| mode_i | input | 1 | 0: interval, 1: pulse-width |
| one_shot_i | input | 1 | Interval: 1 one-shot, 0 reload |
| edge_sel_i | input | 1 | 0: measure high pulse, 1: measure low pulse |
| cnt_en_i | input | 1 | Count-clock enable |
| meas_i | input | 1 | Asynchronous measured pulse |
| gpio_i | input | 1 | General-purpose port value for the pin |
| pin_o | output | 1 | Output pin |
| pin_sel_o | output | 1 | Pin dedicated to the timer output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a capture that lands in the same cycle as a software write clearing the done flag. In that cycle the set must win. To create it, the stimulus drops the measured input, waits exactly the synchronizer depth, and times a control write so that its commit edge is the edge that acts on the detected end edge. Random pulse widths and polarities, and random reload values, are checked against bench functions of the form (256 − P) mod 256. Directed 256-cycle and 300-cycle pulses cover the wrap-around underflow.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_BUF  = 1'b1;

  localparam int BIT_RUN  = 7;
  localparam int BIT_PSEL = 6;
  localparam int BIT_IE   = 5;
  localparam int BIT_UF   = 2;
  localparam int BIT_DONE = 1;
  localparam int BIT_FULL = 0;

  typedef enum logic {MODE_INTERVAL = 1'b0, MODE_PULSE = 1'b1} pwc_mode_e;
endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= d_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             pulse_i,
  input  logic             one_shot_i,
  input  logic             tick_i,
  input  logic             begin_i,
  input  logic             end_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             act_o,
  output logic             uf_o,
  output logic             cap_o,
  output logic             stop_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] MAX = '1;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    uf_o   = 1'b0;
    cap_o  = 1'b0;
    stop_o = 1'b0;
    if (start_i) begin
      cnt_d = pulse_i ? MAX : reload_i;
      act_d = 1'b0;
    end else if (!run_i) begin
      act_d = 1'b0;
    end else if (!pulse_i) begin
      if (tick_i) begin
        if (cnt_q == ONE) begin
          uf_o   = 1'b1;
          stop_o = one_shot_i;
          cnt_d  = one_shot_i ? '0 : reload_i;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end else if (act_q) begin
      if (end_i) begin
        cap_o = 1'b1;       // capture live count, hold it
        act_d = 1'b0;
      end else if (tick_i) begin
        uf_o  = (cnt_q == ONE);
        cnt_d = cnt_q - ONE;  // wraps past zero
      end
    end else if (begin_i) begin
      cnt_d = MAX;
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
  import pwc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic             addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             mode_i,
  input  logic             one_shot_i,
  input  logic             edge_sel_i,
  input  logic             cnt_en_i,
  input  logic             meas_i,
  input  logic             gpio_i,
  output logic             pin_o,
  output logic             pin_sel_o,
  output logic             irq_o
);
  logic run_q, psel_q, ie_q, uf_q, done_q, full_q, tout_q;
  logic [WIDTH-1:0] buf_q;
  logic [WIDTH-1:0] cnt;
  logic meas_act, uf_evt, cap_evt, stop_evt;
  logic ctrl_we, buf_we, buf_re, start, run_eff;
  logic rise, fall, begin_edge, end_edge;
  logic pulse_mode;
  logic [7:0] ctrl_rd;
  logic unused_wbits;

  assign pulse_mode = (pwc_mode_e'(mode_i) == MODE_PULSE);
  assign ctrl_we    = we_i & (addr_i == ADDR_CTRL);
  assign buf_we     = we_i & (addr_i == ADDR_BUF);
  assign buf_re     = re_i & (addr_i == ADDR_BUF);
  assign start      = ctrl_we & wdata_i[BIT_RUN] & ~run_q;
  // a write dropping run takes effect in its own cycle so no capture slips in
  assign run_eff    = run_q & ~(ctrl_we & ~wdata_i[BIT_RUN]);
  assign unused_wbits = ^wdata_i[4:3];

  pwc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (meas_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign begin_edge = edge_sel_i ? fall : rise;
  assign end_edge   = edge_sel_i ? rise : fall;

  pwc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .run_i      (run_eff),
    .pulse_i    (pulse_mode),
    .one_shot_i (one_shot_i),
    .tick_i     (cnt_en_i),
    .begin_i    (begin_edge),
    .end_i      (end_edge),
    .reload_i   (buf_q),
    .cnt_o      (cnt),
    .act_o      (meas_act),
    .uf_o       (uf_evt),
    .cap_o      (cap_evt),
    .stop_o     (stop_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      psel_q <= 1'b0;
      ie_q   <= 1'b0;
      uf_q   <= 1'b0;
      done_q <= 1'b0;
      full_q <= 1'b0;
      tout_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (ctrl_we) begin
        run_q  <= wdata_i[BIT_RUN];
        psel_q <= wdata_i[BIT_PSEL];
        ie_q   <= wdata_i[BIT_IE];
      end else if (stop_evt) begin
        run_q <= 1'b0;
      end
      // set beats a clearing write
      if (uf_evt)                            uf_q <= 1'b1;
      else if (ctrl_we && !wdata_i[BIT_UF])  uf_q <= 1'b0;
      if (cap_evt)                           done_q <= 1'b1;
      else if (ctrl_we && !wdata_i[BIT_DONE]) done_q <= 1'b0;
      if (cap_evt)     full_q <= 1'b1;
      else if (buf_re) full_q <= 1'b0;
      if (uf_evt && !pulse_mode) tout_q <= ~tout_q;
      if (cap_evt)     buf_q <= cnt;
      else if (buf_we) buf_q <= wdata_i;
    end
  end

  assign ctrl_rd   = {run_q, psel_q, ie_q, 2'b00, uf_q, done_q, full_q};
  assign rdata_o   = (addr_i == ADDR_CTRL) ? WIDTH'(ctrl_rd) : buf_q;
  assign pin_sel_o = psel_q;
  assign pin_o     = psel_q ? tout_q : gpio_i;
  assign irq_o     = ie_q & (uf_q | done_q | full_q);
endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             re_i,
  input logic             addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             mode_i,
  input logic             one_shot_i,
  input logic             cnt_en_i,
  input logic             run_q,
  input logic             uf_q,
  input logic             done_q,
  input logic             full_q,
  input logic [WIDTH-1:0] buf_q,
  input logic [WIDTH-1:0] cnt
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == 1'b0);

  // R8
  uf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q && !ctrl_wr |=> uf_q);

  // R9
  full_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_q) |-> $past(re_i && addr_i == 1'b1));

  // R4
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !mode_i && one_shot_i && cnt_en_i && cnt == WIDTH'(1) && !ctrl_wr |=> !run_q);

  // R3
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !mode_i && !one_shot_i && cnt_en_i && cnt == WIDTH'(1) && !we_i |=> cnt == $past(buf_q));

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wdata_i[7] && mode_i |=> buf_q == $past(buf_q));

  // R5
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> full_q);
endmodule

bind pwc_timer pwc_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .re_i       (re_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .mode_i     (mode_i),
  .one_shot_i (one_shot_i),
  .cnt_en_i   (cnt_en_i),
  .run_q      (run_q),
  .uf_q       (uf_q),
  .done_q     (done_q),
  .full_q     (full_q),
  .buf_q      (buf_q),
  .cnt        (cnt)
);

// File: tb/pwc_timer_tb.sv
module pwc_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, re = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic mode = 0, one_shot = 0, edge_sel = 0, cnt_en = 1, meas = 0, gpio = 0;
  logic pin, pin_sel, irq;
  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pwc_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mode_i(mode), .one_shot_i(one_shot),
    .edge_sel_i(edge_sel), .cnt_en_i(cnt_en), .meas_i(meas), .gpio_i(gpio),
    .pin_o(pin), .pin_sel_o(pin_sel), .irq_o(irq)
  );

  function automatic int exp_cap(int p);
    return (256 - p) & 255;
  endfunction

  function automatic int exp_uf(int p);
    return (p >= 256) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic interval_run(input int b, input bit os);
    logic t0;
    logic [7:0] d;
    mode = 0; one_shot = os;
    wr(1, 8'(b));
    wr(0, 8'hC0);
    t0 = pin;
    step(b - 1);
    chk("R2 no toggle before B", pin, t0);
    step(1);
    chk("R2 toggle at B", pin, !t0);
    if (!os) begin
      step(b);
      chk("R3 reload period", pin, t0);
    end else begin
      step(2 * b);
      chk("R4 no further toggle", pin, !t0);
      rd(0, d);
      chk("R4 run cleared", d[7], 0);
    end
    rd(0, d);
    chk("R2 underflow flag", d[2], 1);
    wr(0, 8'h40);
  endtask

  // pulse of p cycles; ends at negedge after action edge
  task automatic pulse(input int p);
    @(negedge clk); meas = !edge_sel;
    step(p);
    meas = edge_sel;
    step(5);
  endtask

  task automatic measure(input int p, input bit es, output logic [7:0] cap, output logic [7:0] ctl);
    mode = 1;
    wr(0, 8'h20);
    edge_sel = es; meas = es;
    step(5);
    wr(0, 8'hA0);
    pulse(p);
    rd(0, ctl);
    rd(1, cap);
  endtask

  initial begin
    logic [7:0] d, c;
    int seed;
    seed = $urandom(32'h5a17);
    step(2);
    rst_n = 1;
    gpio = 1;
    step(1);
    // reset state
    rd(0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(1, d); chk("R1 data reset", d, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R1 pin follows gpio", pin, 1);
    gpio = 0; #1;
    chk("R11 pin follows gpio low", pin, 0);

    // unused bits
    wr(0, 8'h58);
    rd(0, d); chk("R12 bits 4:3 read zero", d, 8'h40);
    chk("R11 pin select out", pin_sel, 1);

    // interval, directed and random
    interval_run(2, 0);
    interval_run(7, 1);
    for (int i = 0; i < 4; i++) interval_run(2 + ($urandom % 40), 0);
    for (int i = 0; i < 2; i++) interval_run(2 + ($urandom % 40), 1);

    // count enable gating
    mode = 0; one_shot = 0;
    wr(1, 8'd5);
    wr(0, 8'hC0);
    begin
      logic t0;
      t0 = pin;
      cnt_en = 0;
      step(10);
      chk("R2 gated hold", pin, t0);
      cnt_en = 1;
      step(4);
      chk("R2 enabled no early", pin, t0);
      step(1);
      chk("R2 enabled toggle", pin, !t0);
    end
    wr(0, 8'h00);
    gpio = 1; #1;
    chk("R11 pin back to gpio", pin, 1);
    gpio = 0;

    // measurement, directed
    measure(10, 0, d, c);
    chk("R5 high pulse capture", d, exp_cap(10));
    chk("R5 done and full set", c[1:0], 2'b11);
    chk("R10 irq with done", irq, 1);
    rd(0, c);
    chk("R9 full cleared by read", c[0], 0);
    wr(0, 8'h83);
    chk("R10 irq off when disabled", irq, 0);
    rd(0, c);
    chk("R8 write one keeps done", c[1], 1);
    wr(0, 8'hA0);
    rd(0, c);
    chk("R8 write zero clears done", c[1], 0);

    measure(20, 1, d, c);
    chk("R5 low pulse capture", d, exp_cap(20));

    // long pulses
    measure(256, 0, d, c);
    chk("R6 256 capture", d, exp_cap(256));
    chk("R6 256 underflow", c[2], exp_uf(256));
    measure(300, 1, d, c);
    chk("R6 300 capture", d, exp_cap(300));
    chk("R6 300 underflow", c[2], exp_uf(300));
    measure(255, 0, d, c);
    chk("R6 255 no underflow", c[2], exp_uf(255));

    // random widths and polarities
    for (int i = 0; i < 8; i++) begin
      int p;
      bit es;
      p = 2 + ($urandom % 250);
      es = 1'($urandom % 2);
      measure(p, es, d, c);
      chk("R5 random capture", d, exp_cap(p));
    end

    // set wins against clearing write (done currently set)
    edge_sel = 0; meas = 0;
    @(negedge clk); meas = 1;
    step(30);
    meas = 0;
    step(1);
    wr(0, 8'hA0);
    rd(0, c);
    chk("R8 set beats clear", c[1], 1);
    rd(1, d);
    chk("R8 capture in collision", d, exp_cap(30));

    // abort
    wr(0, 8'hA0);
    @(negedge clk); meas = 1;
    step(20);
    wr(0, 8'h20);
    meas = 0;
    step(6);
    rd(1, c);
    chk("R7 abort keeps data", c, d);
    rd(0, c);
    chk("R7 abort no done", c[1:0], 2'b00);
    measure(12, 0, d, c);
    chk("R7 rearm captures from FF", d, exp_cap(12));

    // buffer write in interval mode, read back
    wr(0, 8'h00);
    wr(1, 8'h3C);
    rd(1, d);
    chk("R2 data register write", d, 8'h3C);

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule